// File: doc/BRIEF.md
# Wrapping Page Write Buffer

This block stages one page of write data between a serial write front-end and a memory array. A write sequence begins with a start request that captures a page number and a starting byte offset. Each later load request places one data byte at the current offset and then advances the offset. The offset wraps back to zero at the end of the page and never carries into the page number. When more bytes arrive than the page has room for, the later bytes overwrite the earlier ones.

A per-offset valid mask records which bytes belong to the current sequence. A commit request scans the page one offset per cycle. It writes only the marked bytes into a behavioural memory array and leaves the rest of the page as it was. The array is part of the block so that verification can read it back. An abort request empties the mask, which turns a later commit into a no-op. A one-cycle done pulse closes each commit. The front-end can watch the busy output to hold off new requests.

Top module: `pgbuf_top`

## Requirements
- R1: After reset every byte of the memory array reads 0xFF, busy_o is 0 and done_o is 0.
- R2: An accepted start request captures the page number from page_i and the offset from ofs_i. The page stays fixed until the next accepted start request.
- R3: Each accepted load request stores data_i at the current offset and then advances the offset by one. From the last offset of the page (2^OFS_W - 1) it goes to 0 in the same page.
- R4: When loads wrap, a later byte at an offset replaces the earlier byte at that offset. The commit writes the latest value.
- R5: A commit writes exactly the offsets loaded since the last accepted start. Every other byte of the memory stays unchanged.
- R6: An accepted start clears all marks left from earlier loads, so bytes loaded before it are never committed.
- R7: An accepted abort request clears all marks, so a following commit changes no memory byte.
- R8: After an accepted commit request, busy_o is 1 for exactly 2^OFS_W + 1 cycles starting the next cycle. done_o is 1 only in the last of those cycles. All marks are cleared when the commit ends.
- R9: While busy_o is 1, start, load, abort and commit requests are ignored. Buffer contents, page and offset stay unchanged.
- R10: When the block is not busy and several requests arrive in one cycle, start wins over abort, abort wins over load, and commit is accepted only when start, abort and load are all 0.
- R11: rd_data_o shows, in the same cycle without a clock, the memory byte at page rd_page_i and offset rd_ofs_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a write sequence |
| page_i | input | PAGE_W | Page number captured at start |
| ofs_i | input | OFS_W | Starting byte offset captured at start |
| load_i | input | 1 | Load one data byte |
| data_i | input | DATA_W | Byte to load |
| abort_i | input | 1 | Discard the current sequence |
| commit_i | input | 1 | Write the marked bytes to memory |
| busy_o | output | 1 | Commit in progress |
| done_o | output | 1 | One-cycle pulse at the end of a commit |
| rd_page_i | input | PAGE_W | Read-port page number |
| rd_ofs_i | input | OFS_W | Read-port offset |
| rd_data_o | output | DATA_W | Memory byte at the read address |

## Verification
The assertions check several rules on every cycle. The offset wraps after a load at the last offset. A start clears the mask and an abort empties it. The page holds between starts. Buffer and offset stay frozen while busy. The done pulse lasts one cycle, and every array write lands. Only the bench scenarios can show the end-to-end result: which bytes of a page end up in memory after overlapping, wrapped, restarted, aborted or mixed-request sequences. The bench shows this by sweeping every page and every start offset with load counts that both stop short of the page end and run past it.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;

  typedef enum logic [1:0] {
    CM_IDLE = 2'd0,
    CM_SCAN = 2'd1,
    CM_DONE = 2'd2
  } cm_state_e;

  // offset after one load inside a page of n bytes
  function automatic int unsigned wrap_next(int unsigned ofs, int unsigned n);
    return (ofs + 1) % n;
  endfunction

  // flat array address of a byte in a page
  function automatic int unsigned flat_addr(int unsigned page, int unsigned ofs,
                                            int unsigned ofs_w);
    return (page << ofs_w) | ofs;
  endfunction

endpackage

// File: rtl/pgbuf_stage.sv
module pgbuf_stage #(
  parameter int OFS_W  = 6,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           busy_i,
  input  logic                           clr_i,
  input  logic                           start_i,
  input  logic [PAGE_W-1:0]              page_i,
  input  logic [OFS_W-1:0]               ofs_i,
  input  logic                           load_i,
  input  logic [DATA_W-1:0]              data_i,
  input  logic                           abort_i,
  output logic [PAGE_W-1:0]              page_o,
  output logic [OFS_W-1:0]               ofs_o,
  output logic [(1<<OFS_W)-1:0]          mask_o,
  output logic [(1<<OFS_W)-1:0][DATA_W-1:0] buf_o,
  output logic                           start_acc_o,
  output logic                           abort_acc_o,
  output logic                           load_acc_o
);
  localparam int N = 1 << OFS_W;

  logic [PAGE_W-1:0]         page_q;
  logic [OFS_W-1:0]          ofs_q;
  logic [OFS_W-1:0]          ofs_nx;
  logic [N-1:0]              mask_q;
  logic [N-1:0][DATA_W-1:0]  buf_q;

  assign start_acc_o = !busy_i && start_i;
  assign abort_acc_o = !busy_i && !start_i && abort_i;
  assign load_acc_o  = !busy_i && !start_i && !abort_i && load_i;

  assign ofs_nx = OFS_W'(pgbuf_pkg::wrap_next(int'(ofs_q), N));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      ofs_q  <= '0;
      mask_q <= '0;
      buf_q  <= '0;
    end else if (clr_i) begin
      mask_q <= '0;
    end else if (start_acc_o) begin
      page_q <= page_i;
      ofs_q  <= ofs_i;
      mask_q <= '0;
    end else if (abort_acc_o) begin
      mask_q <= '0;
    end else if (load_acc_o) begin
      buf_q[ofs_q]  <= data_i;
      mask_q[ofs_q] <= 1'b1;
      ofs_q         <= ofs_nx;
    end
  end

  assign page_o = page_q;
  assign ofs_o  = ofs_q;
  assign mask_o = mask_q;
  assign buf_o  = buf_q;

  p_ofs_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_acc_o && ofs_q == OFS_W'(N-1)) |=> (ofs_q == '0));

  p_load_marks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_acc_o |=> (mask_q[$past(ofs_q)] && buf_q[$past(ofs_q)] == $past(data_i)));

  p_page_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start_acc_o |=> $stable(page_q));

  p_start_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc_o |=> (mask_q == '0 && page_q == $past(page_i) && ofs_q == $past(ofs_i)));

  p_abort_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_acc_o |=> (mask_q == '0));

  p_frozen_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(buf_q) && $stable(ofs_q) && $stable(page_q)));

endmodule

// File: rtl/pgbuf_commit.sv
module pgbuf_commit #(
  parameter int OFS_W  = 6,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_i,
  input  logic                              other_i,
  input  logic [PAGE_W-1:0]                 page_i,
  input  logic [(1<<OFS_W)-1:0]             mask_i,
  input  logic [(1<<OFS_W)-1:0][DATA_W-1:0] buf_i,
  output logic                              busy_o,
  output logic                              done_o,
  output logic                              clr_o,
  output logic                              we_o,
  output logic [PAGE_W+OFS_W-1:0]           waddr_o,
  output logic [DATA_W-1:0]                 wdata_o
);
  import pgbuf_pkg::*;
  localparam int N = 1 << OFS_W;

  cm_state_e        st_q;
  logic [OFS_W-1:0] idx_q;
  logic             accept;
  logic             last_idx;

  assign accept   = (st_q == CM_IDLE) && req_i && !other_i;
  assign last_idx = (idx_q == OFS_W'(N-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= CM_IDLE;
      idx_q <= '0;
    end else begin
      case (st_q)
        CM_IDLE: if (accept) begin
          st_q  <= CM_SCAN;
          idx_q <= '0;
        end
        CM_SCAN: begin
          idx_q <= idx_q + 1'b1;
          if (last_idx) st_q <= CM_DONE;
        end
        default: st_q <= CM_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q != CM_IDLE);
  assign done_o  = (st_q == CM_DONE);
  assign clr_o   = (st_q == CM_DONE);
  assign we_o    = (st_q == CM_SCAN) && mask_i[idx_q];
  assign waddr_o = (PAGE_W+OFS_W)'(flat_addr(int'(page_i), int'(idx_q), OFS_W));
  assign wdata_o = buf_i[idx_q];

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_scan_runs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CM_SCAN && !last_idx) |=> (st_q == CM_SCAN));

  p_busy_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(req_i) && !$past(other_i)));

endmodule

// File: rtl/pgbuf_array.sv
module pgbuf_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));

endmodule

// File: rtl/pgbuf_top.sv
module pgbuf_top #(
  parameter int OFS_W  = 6,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              abort_i,
  input  logic              commit_i,
  output logic              busy_o,
  output logic              done_o,
  input  logic [PAGE_W-1:0] rd_page_i,
  input  logic [OFS_W-1:0]  rd_ofs_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int N      = 1 << OFS_W;
  localparam int ADDR_W = PAGE_W + OFS_W;

  logic                     busy_w, clr_w, we_w;
  logic [PAGE_W-1:0]        page_w;
  logic [OFS_W-1:0]         ofs_w;
  logic [N-1:0]             mask_w;
  logic [N-1:0][DATA_W-1:0] buf_w;
  logic                     start_acc_w, abort_acc_w, load_acc_w;
  logic [ADDR_W-1:0]        waddr_w;
  logic [DATA_W-1:0]        wdata_w;
  logic [ADDR_W-1:0]        raddr_w;

  pgbuf_stage #(.OFS_W(OFS_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_w), .clr_i(clr_w),
    .start_i(start_i), .page_i(page_i), .ofs_i(ofs_i),
    .load_i(load_i), .data_i(data_i), .abort_i(abort_i),
    .page_o(page_w), .ofs_o(ofs_w), .mask_o(mask_w), .buf_o(buf_w),
    .start_acc_o(start_acc_w), .abort_acc_o(abort_acc_w), .load_acc_o(load_acc_w)
  );

  pgbuf_commit #(.OFS_W(OFS_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_commit (
    .clk(clk), .rst_n(rst_n), .req_i(commit_i),
    .other_i(start_i || abort_i || load_i),
    .page_i(page_w), .mask_i(mask_w), .buf_i(buf_w),
    .busy_o(busy_w), .done_o(done_o), .clr_o(clr_w),
    .we_o(we_w), .waddr_o(waddr_w), .wdata_o(wdata_w)
  );

  assign raddr_w = ADDR_W'(pgbuf_pkg::flat_addr(int'(rd_page_i), int'(rd_ofs_i), OFS_W));

  pgbuf_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n), .we_i(we_w), .waddr_i(waddr_w), .wdata_i(wdata_w),
    .raddr_i(raddr_w), .rdata_o(rd_data_o)
  );

  assign busy_o = busy_w;

  p_one_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_acc_w, abort_acc_w, load_acc_w}));

  p_commit_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (mask_w == '0));

endmodule

// File: tb/sim_pgbuf_top.sv
module sim_pgbuf_top;
  localparam int OFS_W  = 3;
  localparam int PAGE_W = 2;
  localparam int DATA_W = 8;
  localparam int N      = 1 << OFS_W;
  localparam int P      = 1 << PAGE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, load_i = 0, abort_i = 0, commit_i = 0;
  logic [PAGE_W-1:0] page_i = '0, rd_page_i = '0;
  logic [OFS_W-1:0]  ofs_i = '0, rd_ofs_i = '0;
  logic [DATA_W-1:0] data_i = '0;
  logic busy_o, done_o;
  logic [DATA_W-1:0] rd_data_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  // requirement-level model
  logic [DATA_W-1:0] m_mem [P*N];
  logic [DATA_W-1:0] m_buf [N];
  bit                m_mask [N];
  int                m_page = 0, m_ofs = 0;

  pgbuf_top #(.OFS_W(OFS_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .page_i(page_i), .ofs_i(ofs_i),
    .load_i(load_i), .data_i(data_i), .abort_i(abort_i), .commit_i(commit_i),
    .busy_o(busy_o), .done_o(done_o), .rd_page_i(rd_page_i), .rd_ofs_i(rd_ofs_i),
    .rd_data_o(rd_data_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_mem(input string req);
    for (int p = 0; p < P; p++) begin
      for (int o = 0; o < N; o++) begin
        rd_page_i = PAGE_W'(p);
        rd_ofs_i  = OFS_W'(o);
        #1;
        chk(rd_data_o === m_mem[p*N+o], req, int'(rd_data_o), int'(m_mem[p*N+o]));
      end
    end
  endtask

  task automatic clear_mask_model();
    for (int o = 0; o < N; o++) m_mask[o] = 0;
  endtask

  task automatic do_start(input int p, input int o);
    start_i = 1; page_i = PAGE_W'(p); ofs_i = OFS_W'(o);
    @(negedge clk); start_i = 0;
    m_page = p; m_ofs = o; clear_mask_model();
  endtask

  task automatic do_load(input logic [DATA_W-1:0] d);
    load_i = 1; data_i = d;
    @(negedge clk); load_i = 0;
    m_buf[m_ofs] = d; m_mask[m_ofs] = 1; m_ofs = (m_ofs + 1) % N;
  endtask

  task automatic do_abort();
    abort_i = 1;
    @(negedge clk); abort_i = 0;
    clear_mask_model();
  endtask

  // inject: drive start/load/abort/commit during the busy window
  task automatic do_commit(input bit inject);
    int cnt, dcnt, dpos;
    commit_i = 1;
    @(negedge clk); commit_i = 0;
    cnt = 0; dcnt = 0; dpos = -1;
    while (busy_o && cnt < 4*N) begin
      if (done_o) begin dcnt++; dpos = cnt; end
      if (inject && cnt == 2) begin
        start_i = 1; load_i = 1; abort_i = 1; commit_i = 1;
        page_i = PAGE_W'(P-1); ofs_i = OFS_W'(N-2); data_i = 8'h5A;
      end else begin
        start_i = 0; load_i = 0; abort_i = 0; commit_i = 0;
      end
      cnt++;
      @(negedge clk);
    end
    start_i = 0; load_i = 0; abort_i = 0; commit_i = 0;
    chk(cnt == N + 1, "R8 busy length", cnt, N + 1);
    chk(dcnt == 1 && dpos == N, "R8 done pulse position", dpos, N);
    for (int o = 0; o < N; o++)
      if (m_mask[o]) m_mem[m_page*N+o] = m_buf[o];
    clear_mask_model();
  endtask

  initial begin
    for (int i = 0; i < P*N; i++) m_mem[i] = 8'hFF;
    for (int o = 0; o < N; o++) begin m_buf[o] = '0; m_mask[o] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(busy_o == 0, "R1 busy after reset", busy_o, 0);
    chk(done_o == 0, "R1 done after reset", done_o, 0);
    check_mem("R1 erased array");

    // R2 R3 R4 R5 R11 sweep of pages, start offsets and load counts
    for (int p = 0; p < P; p++) begin
      for (int o = 0; o < N; o++) begin
        int cnt;
        cnt = 1 + ((p * 5 + o * 3) % (N + 4));
        do_start(p, o);
        for (int k = 0; k < cnt; k++) do_load(DATA_W'(p * 64 + o * 8 + k * 13 + 1));
        do_commit(0);
        check_mem("R3 R4 R5 R11 sweep");
      end
    end

    // R6 restart drops earlier loads
    do_start(1, 2);
    do_load(8'hA1); do_load(8'hA2); do_load(8'hA3);
    do_start(1, 6);
    do_load(8'hB6);
    do_commit(0);
    check_mem("R6 restart");

    // R7 abort empties the sequence
    do_start(2, 0);
    do_load(8'hC0); do_load(8'hC1);
    do_abort();
    do_commit(0);
    check_mem("R7 abort");

    // R9 requests during busy are ignored; R8 mask clears at end
    do_start(3, N - 3);
    do_load(8'hD5); do_load(8'hD6);
    do_commit(1);
    chk(busy_o == 0, "R9 no commit taken during busy", busy_o, 0);
    do_load(8'hE7);
    do_commit(0);
    check_mem("R9 R8 continue after busy");

    // R10 start beats load
    start_i = 1; load_i = 1; page_i = 2'd0; ofs_i = 3'd4; data_i = 8'h11;
    @(negedge clk); start_i = 0; load_i = 0;
    m_page = 0; m_ofs = 4; clear_mask_model();
    do_load(8'h22);
    // abort beats load
    abort_i = 1; load_i = 1; data_i = 8'h33;
    @(negedge clk); abort_i = 0; load_i = 0;
    clear_mask_model();
    do_load(8'h44);
    // load beats commit
    commit_i = 1; load_i = 1; data_i = 8'h55;
    @(negedge clk); commit_i = 0; load_i = 0;
    m_buf[m_ofs] = 8'h55; m_mask[m_ofs] = 1; m_ofs = (m_ofs + 1) % N;
    chk(busy_o == 0, "R10 commit refused with load", busy_o, 0);
    do_commit(0);
    check_mem("R10 priority");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule